// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for a four-beat burst into a synchronous memory. When the access decoder accepts an address strobe, it pulses `load_i`. The sequencer then captures the whole external address. The two least significant bits become the burst start value, and the remaining bits are frozen for the rest of the burst.

Every later cycle in which the active-low advance input is low moves the low two bits to the next beat of the burst. The order of the beats is set by a mode input that is sampled at load time:

- **Linear order:** the start value plus a 2-bit beat count, so the beat wraps around the aligned group of four words.
- **Interleaved order:** the start value XORed with the beat count.

When advance is high and no load occurs, the address holds, which suspends the burst. Read and write bursts use the same stepping. Access-cycle decoding and the memory array belong to other blocks.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after release until the first load, `addr_o` is all zeros.
- R2: In the cycle after a clock edge with `load_i` high, `addr_o` equals the `addr_i` presented at that edge, whatever the mode.
- R3: With linear order latched (`mode_i` = 0 at load), after k advances `addr_o[1:0]` = (start + k) mod 4.
- R4: With interleaved order latched (`mode_i` = 1 at load), after k advances `addr_o[1:0]` = start XOR k (mod 4). For example, start 01 gives 01, 00, 11, 10.
- R5: A clock edge with `load_i` low and `adv_n_i` high leaves `addr_o` unchanged.
- R6: When `load_i` and `adv_n_i` = 0 coincide, the load wins and `addr_o` becomes `addr_i` with no step applied.
- R7: Four advances after a load return `addr_o[1:0]` to the start value in either order.
- R8: `mode_i` is sampled only at a load edge. Changes to it during a burst do not alter the sequence.
- R9: `addr_o[ADDR_W-1:2]` changes only at a load edge, whatever `addr_i` carries in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Accepted address strobe; starts a new burst |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| mode_i | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| addr_i | input | ADDR_W | External word address |
| addr_o | output | ADDR_W | Current burst word address |

## Verification
The bound checker checks the following on every cycle:

- the load capture and its priority over advance;
- hold on a suspended cycle;
- the linear increment and the interleaved XOR step between consecutive cycles;
- the freezing of the upper bits and of the latched mode between loads.

Only the bench scenarios show the behaviour that needs whole sequences: the full four-beat orders from every start value in both modes, the wrap back to the start after four beats, that a mode change in the middle of a burst is ignored, and the reset value seen at the port.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic {
    SEQ_LINEAR     = 1'b0,
    SEQ_INTERLEAVE = 1'b1
  } seq_mode_e;

  // Offset of beat number `beat` for a burst that started at `start`.
  function automatic logic [BEAT_W-1:0] seq_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input seq_mode_e         mode
  );
    logic [BEAT_W-1:0] r;
    if (mode == SEQ_INTERLEAVE) r = start ^ beat;
    else                        r = start + beat;
    return r;
  endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int UPPER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [UPPER_W-1:0] upper_i,
  input  logic [BEAT_W-1:0]  start_i,
  input  seq_mode_e          mode_i,
  output logic [UPPER_W-1:0] upper_o,
  output logic [BEAT_W-1:0]  start_o,
  output seq_mode_e          mode_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_o <= '0;
      start_o <= '0;
      mode_o  <= SEQ_LINEAR;
    end else if (load_i) begin
      upper_o <= upper_i;
      start_o <= start_i;
      mode_o  <= mode_i;
    end
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      beat_o <= '0;
    else if (load_i) beat_o <= '0;
    else if (step_i) beat_o <= beat_o + 1'b1;
  end

endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
  import burst_pkg::*;
(
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  seq_mode_e         mode_i,
  output logic [BEAT_W-1:0] low_o
);

  always_comb low_o = seq_offset(start_i, beat_i, mode_i);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_n_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  // Named events for the checker
  logic step_evt;
  logic hold_evt;
  assign step_evt = !load_i && !adv_n_i;
  assign hold_evt = !load_i &&  adv_n_i;

  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  start_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [BEAT_W-1:0]  low_w;
  seq_mode_e          mode_q;

  burst_base_reg #(.UPPER_W(UPPER_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .upper_i (addr_i[ADDR_W-1:BEAT_W]),
    .start_i (addr_i[BEAT_W-1:0]),
    .mode_i  (seq_mode_e'(mode_i)),
    .upper_o (upper_q),
    .start_o (start_q),
    .mode_o  (mode_q)
  );

  burst_beat_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .step_i (step_evt),
    .beat_o (beat_q)
  );

  burst_seq_map u_map (
    .start_i (start_q),
    .beat_i  (beat_q),
    .mode_i  (mode_q),
    .low_o   (low_w)
  );

  assign addr_o = {upper_q, low_w};

endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              step_evt,
  input logic              hold_evt,
  input seq_mode_e         mode_q,
  input logic [BEAT_W-1:0] start_q,
  input logic [BEAT_W-1:0] beat_q
);

  // R2 and R6: a load captures the full address, even when advance is active
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> addr_o == $past(addr_i));

  // R5: suspend holds the address
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(addr_o));

  // R3: linear step adds one to the low bits, with wrap
  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && mode_q == SEQ_LINEAR) |=>
      addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1));

  // R4: interleaved step is start XOR the next beat number
  assert_interleave_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && mode_q == SEQ_INTERLEAVE) |=>
      addr_o[BEAT_W-1:0] == ($past(start_q) ^ BEAT_W'($past(beat_q) + 1'b1)));

  // R9: upper bits change only on a load
  assert_upper_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  // R8: the latched order changes only on a load
  assert_mode_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mode_q));

endmodule

bind burst_addr_gen burst_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_i   (load_i),
  .addr_i   (addr_i),
  .addr_o   (addr_o),
  .step_evt (step_evt),
  .hold_evt (hold_evt),
  .mode_q   (mode_q),
  .start_q  (start_q),
  .beat_q   (beat_q)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic          adv_n_i = 1'b1;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .adv_n_i (adv_n_i),
    .mode_i  (mode_i),
    .addr_i  (addr_i),
    .addr_o  (addr_o)
  );

  typedef struct packed {
    logic          ld;
    logic          adv_n;
    logic          md;
    logic [AW-1:0] a;
    logic [AW-1:0] e;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 18'h12345, 18'h12345, 4'd2}, // R2 load, interleaved
    '{1'b0, 1'b0, 1'b1, 18'h15555, 18'h12344, 4'd4}, // R4 01^1
    '{1'b0, 1'b0, 1'b1, 18'h15555, 18'h12347, 4'd4}, // R4 01^2
    '{1'b0, 1'b0, 1'b1, 18'h15555, 18'h12346, 4'd4}, // R4 01^3
    '{1'b0, 1'b0, 1'b1, 18'h15555, 18'h12345, 4'd7}, // R7 wrap
    '{1'b0, 1'b1, 1'b0, 18'h15555, 18'h12345, 4'd5}, // R5 hold
    '{1'b1, 1'b0, 1'b0, 18'h0ABCE, 18'h0ABCE, 4'd6}, // R6 load beats advance
    '{1'b0, 1'b0, 1'b1, 18'h00000, 18'h0ABCF, 4'd8}, // R8 mode change ignored
    '{1'b0, 1'b0, 1'b1, 18'h3FFFC, 18'h0ABCC, 4'd3}, // R3 linear wrap 11->00
    '{1'b0, 1'b1, 1'b0, 18'h3FFFC, 18'h0ABCC, 4'd5}, // R5 hold mid-burst
    '{1'b0, 1'b0, 1'b0, 18'h00000, 18'h0ABCD, 4'd3}, // R3
    '{1'b0, 1'b0, 1'b0, 18'h11111, 18'h0ABCE, 4'd7}, // R7 back to start
    '{1'b1, 1'b0, 1'b1, 18'h3FFFF, 18'h3FFFF, 4'd6}, // R6 load, interleaved
    '{1'b0, 1'b0, 1'b0, 18'h00000, 18'h3FFFE, 4'd8}, // R8 11^01
    '{1'b0, 1'b0, 1'b0, 18'h00000, 18'h3FFFD, 4'd9}  // R9 upper held, 11^10
  };

  task automatic check(input string req, input logic [AW-1:0] exp);
    tests++;
    if (addr_o !== exp) begin
      fails++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  task automatic cycle(input logic ld, input logic advn, input logic md,
                       input logic [AW-1:0] a);
    @(negedge clk);
    load_i = ld; adv_n_i = advn; mode_i = md; addr_i = a;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [1:0] bench_low(input int s, input int k, input bit il);
    int r;
    r = il ? (s ^ k) : (s + k);
    return 2'(r % 4);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2 check("R1 in reset", '0);
    @(negedge clk) rst_n = 1'b1;
    cycle(1'b0, 1'b1, 1'b1, 18'h2AAAA);
    check("R1 after release", '0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      cycle(VECS[i].ld, VECS[i].adv_n, VECS[i].md, VECS[i].a);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].e);
    end

    // R3/R4/R7/R9 sweep: every start value, both orders
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-3:0] up;
        up = 16'hA5A0 + 16'(s) + 16'(m * 8);
        cycle(1'b1, 1'b1, m[0], {up, 2'(s)});
        check("R2 sweep load", {up, 2'(s)});
        for (int k = 1; k <= 4; k++) begin
          cycle(1'b0, 1'b0, ~m[0], {~up, 2'(k)});
          check(m ? "R4 sweep" : "R3 sweep", {up, bench_low(s, k, m[0])});
        end
      end
    end

    // R1: asynchronous reset mid-burst
    cycle(1'b1, 1'b1, 1'b0, 18'h1F00F);
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1 mid-burst reset", '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule